// File: doc/BRIEF.md
# Message Acknowledge and Retry Controller

This block sits between a request interface that asks for a message to be sent and the packet encoder and decoder of a power-delivery link. When asked, it hands a 16-bit header to the encoder and then watches the decoder's output for an acknowledgement. The acknowledgement is a GoodCRC control message with no data objects that carries the same message ID as the header that was sent. If no acknowledgement arrives within a programmable number of cycles, the block sends the message again. It keeps doing this until a fixed limit of attempts is used up. A hard-reset request goes out once and does not wait for an acknowledgement.

The block also answers the link partner. Any valid received message that is not itself a zero-object GoodCRC is answered with a GoodCRC. The answer carries the received ID and the local power and data role bits. Every outcome is reported as a sticky alert bit, and a read strobe clears the bits. After a good acknowledgement the receive side is blanked for a fixed number of cycles, so that trailing edges on the line are not taken as a new packet.

Top module: `msg_ack_retry`

## Requirements
- R1: Out of reset, `alerts` is 0 and `sendStart` is low.
- R2: A `txReq` pulse is accepted only when no request is pending. An accepted request leads to a one-cycle `sendStart` pulse with `sendHeader` equal to the requested header. A `txReq` that arrives while a request is pending is ignored.
- R3: An attempt succeeds only when a received valid packet has type 4'h1 in bits 3:0, zero in bits 14:12 and, in bits 11:9, the ID of the header sent. Success sets alert bit 2, and no further send follows.
- R4: The acknowledgement is accepted in any of the `ackTimeout` cycles that follow the cycle in which `sendDone` is seen. If none arrives in that window, the message is sent again.
- R5: A message is sent at most RETRY_LIMIT+1 times in total. When the last attempt times out, alert bit 3 is set and sending stops.
- R6: A valid packet other than the expected acknowledgement, received while waiting, ends the transfer at once. This includes a GoodCRC with a wrong ID or a nonzero count. The transfer ends with alert bit 4 and no retry. A received hard reset during the wait has the same effect.
- R7: A `sendCollide` during a message or hard-reset send ends the transfer with alert bit 4 and no retry.
- R8: A hard-reset request is sent with `sendHardReset` high. Alert bit 2 is set in the same cycle as its `sendDone`, and no acknowledgement wait follows.
- R9: Each valid received message that is not a zero-object GoodCRC is answered by a send with header bit 15 = 0, bits 14:12 = 0, bits 11:9 = received ID, bit 8 = `powerRole`, bits 7:6 = 0, bit 5 = `dataRole`, bit 4 = 0 and bits 3:0 = 4'h1. A pending answer is sent before a pending request. A zero-object GoodCRC is never answered.
- R10: A valid received message sets alert bit 0, except an acknowledgement taken by a waiting transfer. A received hard reset sets alert bit 1.
- R11: Alert bits accumulate by OR. `alertRead` clears them at the next edge, and a bit set in that same cycle survives the clear.
- R12: For BLANK_CYCLES cycles after an accepted acknowledgement, `rxValid` and `rxHardReset` are ignored: they raise no alert and cause no answer. The next cycle receives normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txReq | input | 1 | One-cycle transmit request |
| txHardReset | input | 1 | With `txReq`: request is a hard reset |
| txHeader | input | 16 | Header of the requested message |
| ackTimeout | input | TIMER_W | Acknowledgement window in cycles (at least 1) |
| powerRole | input | 1 | Local power role bit for answers |
| dataRole | input | 1 | Local data role bit for answers |
| sendStart | output | 1 | One-cycle start pulse to the encoder |
| sendHeader | output | 16 | Header for the encoder, held until the next start |
| sendHardReset | output | 1 | Encoder must send a hard-reset sequence |
| sendDone | input | 1 | Encoder finished sending |
| sendCollide | input | 1 | Encoder saw a collision and did not send |
| rxValid | input | 1 | Decoder delivers a valid packet header |
| rxHeader | input | 16 | Received header |
| rxHardReset | input | 1 | Decoder saw a hard-reset sequence |
| alertRead | input | 1 | Read strobe that clears the alerts |
| alerts | output | 5 | Bit 0 rx message, 1 rx hard reset, 2 tx success, 3 tx failed, 4 tx discarded |

## Verification
The bench sweeps the arrival of the acknowledgement across the whole window for several timeouts, up to one cycle past the end. A counter that is off by one would retransmit on a good acknowledgement, or accept a late one. It pairs every sent ID with every returned ID. A design that ignores the ID, or retries after a mismatch, would show success or an extra send. It moves a received message across every cycle of the blanking window and its first cycle after, which exposes a window that is too short or too long. It also checks that an answer goes out ahead of a waiting request, that a clear which lands together with a new event keeps the new bit, and that a hard-reset send reports success without waiting.

// File: rtl/ackretry_pkg.sv
package ackretry_pkg;

  localparam int HDR_W   = 16;
  localparam int ALERT_W = 5;

  localparam int AL_RXMSG = 0;
  localparam int AL_RXHRD = 1;
  localparam int AL_OK    = 2;
  localparam int AL_FAIL  = 3;
  localparam int AL_DISC  = 4;

  localparam logic [3:0] GOODCRC_TYPE = 4'h1;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_AWAIT} ctlState_t;
  typedef enum logic [1:0] {K_REPLY, K_MSG, K_HARD}     sendKind_t;

  // control -> datapath strobes, all single-cycle
  typedef struct packed {
    logic startReply;
    logic startMsg;
    logic clearTx;
    logic okAlert;
    logic failAlert;
    logic discAlert;
    logic ackTaken;
    logic startBlank;
  } ctlStrobe_t;

  function automatic logic isBareGoodCrc(input logic [HDR_W-1:0] hdr);
    return (hdr[3:0] == GOODCRC_TYPE) && (hdr[14:12] == 3'd0);
  endfunction

endpackage

// File: rtl/ackretry_dp.sv
module ackretry_dp
  import ackretry_pkg::*;
#(
  parameter int BLANK_CYCLES = 5000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txReq,
  input  logic               txHardReset,
  input  logic [HDR_W-1:0]   txHeader,
  input  logic               powerRole,
  input  logic               dataRole,
  input  logic               rxValid,
  input  logic [HDR_W-1:0]   rxHeader,
  input  logic               rxHardReset,
  input  logic               alertRead,
  input  ctlStrobe_t         strb,
  output logic               txPend,
  output logic               txHardQ,
  output logic               replyPend,
  output logic               rxAck,
  output logic               rxOther,
  output logic               rxHardSeen,
  output logic               sendStart,
  output logic [HDR_W-1:0]   sendHeader,
  output logic               sendHardReset,
  output logic [ALERT_W-1:0] alerts
);

  localparam int BLK_W = (BLANK_CYCLES < 1) ? 1 : $clog2(BLANK_CYCLES + 1);

  logic [HDR_W-1:0]   txHdrQ;
  logic [2:0]         replyId;
  logic [BLK_W-1:0]   blankCnt;
  logic               rxLive;
  logic               rxMsg;
  logic               rxIsBare;
  logic [HDR_W-1:0]   replyHdr;
  logic [ALERT_W-1:0] alertSet;
  logic               unusedRxBits;

  assign unusedRxBits = ^{rxHeader[15], rxHeader[8:4]};

  // receive qualification
  generate
    if (BLANK_CYCLES > 0) begin : g_blank
      always_ff @(posedge clk) begin
        if (!rstN)                blankCnt <= '0;
        else if (strb.startBlank) blankCnt <= BLK_W'(BLANK_CYCLES);
        else if (blankCnt != '0)  blankCnt <= blankCnt - BLK_W'(1);
      end
      assign rxLive = (blankCnt == '0);
    end else begin : g_noblank
      assign blankCnt = '0;
      assign rxLive   = 1'b1;
    end
  endgenerate

  assign rxMsg      = rxLive & rxValid;
  assign rxIsBare   = isBareGoodCrc(rxHeader);
  assign rxAck      = rxMsg & rxIsBare & (rxHeader[11:9] == txHdrQ[11:9]);
  assign rxOther    = rxMsg & ~rxAck;
  assign rxHardSeen = rxLive & rxHardReset;

  // pending request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPend  <= 1'b0;
      txHardQ <= 1'b0;
      txHdrQ  <= '0;
    end else if (strb.clearTx) begin
      txPend  <= 1'b0;
    end else if (txReq && !txPend) begin
      txPend  <= 1'b1;
      txHardQ <= txHardReset;
      txHdrQ  <= txHeader;
    end
  end

  // pending answer, depth one; a newer message overwrites the ID
  always_ff @(posedge clk) begin
    if (!rstN) begin
      replyPend <= 1'b0;
      replyId   <= '0;
    end else if (rxMsg && !rxIsBare) begin
      replyPend <= 1'b1;
      replyId   <= rxHeader[11:9];
    end else if (strb.startReply) begin
      replyPend <= 1'b0;
    end
  end

  assign replyHdr = {1'b0, 3'd0, replyId, powerRole, 2'b00, dataRole, 1'b0, GOODCRC_TYPE};

  // encoder side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendStart     <= 1'b0;
      sendHeader    <= '0;
      sendHardReset <= 1'b0;
    end else begin
      sendStart <= strb.startReply | strb.startMsg;
      if (strb.startReply) begin
        sendHeader    <= replyHdr;
        sendHardReset <= 1'b0;
      end else if (strb.startMsg) begin
        sendHeader    <= txHdrQ;
        sendHardReset <= txHardQ;
      end
    end
  end

  // sticky alerts, set wins over read
  always_comb begin
    alertSet           = '0;
    alertSet[AL_RXMSG] = rxMsg & ~strb.ackTaken;
    alertSet[AL_RXHRD] = rxHardSeen;
    alertSet[AL_OK]    = strb.okAlert;
    alertSet[AL_FAIL]  = strb.failAlert;
    alertSet[AL_DISC]  = strb.discAlert;
  end

  always_ff @(posedge clk) begin
    if (!rstN) alerts <= '0;
    else       alerts <= (alertRead ? '0 : alerts) | alertSet;
  end

endmodule

// File: rtl/ackretry_ctrl.sv
module ackretry_ctrl
  import ackretry_pkg::*;
#(
  parameter int RETRY_LIMIT = 3,
  parameter int TIMER_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] ackTimeout,
  input  logic               txPend,
  input  logic               txHardQ,
  input  logic               replyPend,
  input  logic               rxAck,
  input  logic               rxOther,
  input  logic               rxHardSeen,
  input  logic               sendDone,
  input  logic               sendCollide,
  output ctlStrobe_t         strb
);

  localparam int ATT_W = (RETRY_LIMIT < 1) ? 1 : $clog2(RETRY_LIMIT + 1);

  ctlState_t          state, stateN;
  sendKind_t          kind, kindN;
  logic [ATT_W-1:0]   attempt, attemptN;
  logic [TIMER_W-1:0] timer, timerN;

  always_comb begin
    strb     = '0;
    stateN   = state;
    kindN    = kind;
    attemptN = attempt;
    timerN   = timer;
    unique case (state)
      ST_IDLE: begin
        if (replyPend) begin
          strb.startReply = 1'b1;
          kindN           = K_REPLY;
          stateN          = ST_SEND;
        end else if (txPend) begin
          strb.startMsg = 1'b1;
          kindN         = txHardQ ? K_HARD : K_MSG;
          stateN        = ST_SEND;
        end
      end
      ST_SEND: begin
        if (sendCollide) begin
          if (kind != K_REPLY) begin
            strb.discAlert = 1'b1;
            strb.clearTx   = 1'b1;
          end
          stateN = ST_IDLE;
        end else if (sendDone) begin
          unique case (kind)
            K_MSG: begin
              stateN = ST_AWAIT;
              timerN = '0;
            end
            K_HARD: begin
              strb.okAlert = 1'b1;
              strb.clearTx = 1'b1;
              stateN       = ST_IDLE;
            end
            default: stateN = ST_IDLE;
          endcase
        end
      end
      ST_AWAIT: begin
        if (rxAck) begin
          strb.ackTaken   = 1'b1;
          strb.okAlert    = 1'b1;
          strb.clearTx    = 1'b1;
          strb.startBlank = 1'b1;
          stateN          = ST_IDLE;
        end else if (rxOther || rxHardSeen) begin
          strb.discAlert = 1'b1;
          strb.clearTx   = 1'b1;
          stateN         = ST_IDLE;
        end else if (timer == ackTimeout - TIMER_W'(1)) begin
          if (attempt == ATT_W'(RETRY_LIMIT)) begin
            strb.failAlert = 1'b1;
            strb.clearTx   = 1'b1;
          end else begin
            attemptN = attempt + ATT_W'(1);
          end
          stateN = ST_IDLE;
        end else begin
          timerN = timer + TIMER_W'(1);
        end
      end
      default: stateN = ST_IDLE;
    endcase
    if (strb.clearTx) attemptN = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= K_REPLY;
      attempt <= '0;
      timer   <= '0;
    end else begin
      state   <= stateN;
      kind    <= kindN;
      attempt <= attemptN;
      timer   <= timerN;
    end
  end

endmodule

// File: rtl/msg_ack_retry.sv
module msg_ack_retry
  import ackretry_pkg::*;
#(
  parameter int RETRY_LIMIT  = 3,
  parameter int TIMER_W      = 16,
  parameter int BLANK_CYCLES = 5000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txReq,
  input  logic               txHardReset,
  input  logic [15:0]        txHeader,
  input  logic [TIMER_W-1:0] ackTimeout,
  input  logic               powerRole,
  input  logic               dataRole,
  output logic               sendStart,
  output logic [15:0]        sendHeader,
  output logic               sendHardReset,
  input  logic               sendDone,
  input  logic               sendCollide,
  input  logic               rxValid,
  input  logic [15:0]        rxHeader,
  input  logic               rxHardReset,
  input  logic               alertRead,
  output logic [4:0]         alerts
);

  ctlStrobe_t strb;
  logic txPend, txHardQ, replyPend, rxAck, rxOther, rxHardSeen;

  ackretry_ctrl #(
    .RETRY_LIMIT(RETRY_LIMIT),
    .TIMER_W    (TIMER_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ackTimeout (ackTimeout),
    .txPend     (txPend),
    .txHardQ    (txHardQ),
    .replyPend  (replyPend),
    .rxAck      (rxAck),
    .rxOther    (rxOther),
    .rxHardSeen (rxHardSeen),
    .sendDone   (sendDone),
    .sendCollide(sendCollide),
    .strb       (strb)
  );

  ackretry_dp #(
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .txReq        (txReq),
    .txHardReset  (txHardReset),
    .txHeader     (txHeader),
    .powerRole    (powerRole),
    .dataRole     (dataRole),
    .rxValid      (rxValid),
    .rxHeader     (rxHeader),
    .rxHardReset  (rxHardReset),
    .alertRead    (alertRead),
    .strb         (strb),
    .txPend       (txPend),
    .txHardQ      (txHardQ),
    .replyPend    (replyPend),
    .rxAck        (rxAck),
    .rxOther      (rxOther),
    .rxHardSeen   (rxHardSeen),
    .sendStart    (sendStart),
    .sendHeader   (sendHeader),
    .sendHardReset(sendHardReset),
    .alerts       (alerts)
  );

endmodule

// File: rtl/ackretry_chk.sv
module ackretry_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sendStart,
  input logic [15:0] sendHeader,
  input logic        rxValid,
  input logic        rxHardReset,
  input logic        alertRead,
  input logic [4:0]  alerts
);

  // R2: the encoder start is a single-cycle pulse
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    sendStart |=> !sendStart);

  // R2: the header for the encoder only moves together with a start
  assert_header_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sendStart |-> $stable(sendHeader));

  // R5: at most one transfer outcome appears in any cycle
  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(alerts[4:2] & ~$past(alerts[4:2])));

  // R11: without a read no alert bit drops
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    !alertRead |=> ((alerts & $past(alerts)) == $past(alerts)));

  // R11: a read with no receive event clears the receive alerts
  assert_rx_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (alertRead && !rxValid && !rxHardReset) |=> (alerts[1:0] == 2'b00));

endmodule

bind msg_ack_retry ackretry_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sendStart  (sendStart),
  .sendHeader (sendHeader),
  .rxValid    (rxValid),
  .rxHardReset(rxHardReset),
  .alertRead  (alertRead),
  .alerts     (alerts)
);

// File: tb/sim_msg_ack_retry.sv
`timescale 1ns/1ps
module sim_msg_ack_retry;

  localparam int RL = 3;
  localparam int BL = 5;

  logic        clk = 1'b0;
  logic        rstN;
  logic        txReq, txHardReset;
  logic [15:0] txHeader;
  logic [15:0] ackTimeout;
  logic        powerRole, dataRole;
  logic        sendStart, sendHardReset;
  logic [15:0] sendHeader;
  logic        sendDone, sendCollide;
  logic        rxValid, rxHardReset;
  logic [15:0] rxHeader;
  logic        alertRead;
  logic [4:0]  alerts;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  msg_ack_retry #(.RETRY_LIMIT(RL), .TIMER_W(16), .BLANK_CYCLES(BL)) u0 (
    .clk(clk), .rstN(rstN), .txReq(txReq), .txHardReset(txHardReset),
    .txHeader(txHeader), .ackTimeout(ackTimeout), .powerRole(powerRole),
    .dataRole(dataRole), .sendStart(sendStart), .sendHeader(sendHeader),
    .sendHardReset(sendHardReset), .sendDone(sendDone), .sendCollide(sendCollide),
    .rxValid(rxValid), .rxHeader(rxHeader), .rxHardReset(rxHardReset),
    .alertRead(alertRead), .alerts(alerts));

  function automatic logic [15:0] mk(input int typ, input int cnt, input int id);
    return {1'b0, 3'(cnt), 3'(id), 5'd0, 4'(typ)};
  endfunction

  function automatic logic [15:0] replyOf(input int id, input logic pr, input logic dr);
    return {1'b0, 3'd0, 3'(id), pr, 2'b00, dr, 1'b0, 4'h1};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic request(input logic [15:0] hdr, input logic hard);
    txHeader = hdr; txHardReset = hard; txReq = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
  endtask

  task automatic waitStart(input int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc; i++) begin
      if (sendStart) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic pulseDone();
    sendDone = 1'b1; @(negedge clk); sendDone = 1'b0;
  endtask

  task automatic pulseCollide();
    sendCollide = 1'b1; @(negedge clk); sendCollide = 1'b0;
  endtask

  task automatic rxPkt(input logic [15:0] hdr);
    rxHeader = hdr; rxValid = 1'b1; @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic readAlerts(output logic [4:0] a);
    a = alerts; alertRead = 1'b1; @(negedge clk); alertRead = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [4:0] a;
    int n;
    rstN = 0; txReq = 0; txHardReset = 0; txHeader = '0; ackTimeout = 16'd8;
    powerRole = 0; dataRole = 0; sendDone = 0; sendCollide = 0;
    rxValid = 0; rxHeader = '0; rxHardReset = 0; alertRead = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset alerts", alerts, 0);
    chk("R1 reset start", sendStart, 0);

    // R4: acknowledgement position swept across the window and one past it
    for (int t = 1; t <= 4; t++) begin
      for (int k = 1; k <= t + 1; k++) begin
        ackTimeout = 16'(t);
        request(mk(2, 1, k), 1'b0);
        waitStart(10, got);
        chk("R2 start seen", got, 1);
        chk("R2 header", sendHeader, mk(2, 1, k));
        chk("R2 not hard", sendHardReset, 0);
        pulseDone();
        repeat (k - 1) @(negedge clk);
        rxPkt(mk(1, 0, k));
        if (k <= t) begin
          waitStart(t + 4, got);
          chk("R4 in-window ack no resend", got, 0);
          readAlerts(a);
          chk("R4 in-window ack result", a, 5'b00100);
        end else begin
          waitStart(4, got);
          chk("R4 late ack resend", got, 1);
          pulseDone();
          rxPkt(mk(1, 0, k));
          waitStart(t + 4, got);
          chk("R4 second ack no resend", got, 0);
          readAlerts(a);
          chk("R4 late ack result", a, 5'b00101);
        end
        repeat (BL + 3) @(negedge clk);
      end
    end

    // R5: attempt count for several timeouts
    for (int t = 1; t <= 3; t++) begin
      ackTimeout = 16'(t);
      request(mk(5, 0, 3), 1'b0);
      n = 0;
      for (int i = 0; i < 10; i++) begin
        waitStart(t + 6, got);
        if (!got) break;
        n++;
        pulseDone();
      end
      chk("R5 attempts", n, RL + 1);
      readAlerts(a);
      chk("R5 failed alert", a, 5'b01000);
    end

    // R3 and R6: every sent ID against every returned ID
    ackTimeout = 16'd20;
    for (int sid = 0; sid < 8; sid++) begin
      for (int d = 0; d < 8; d++) begin
        request(mk(4, 1, sid), 1'b0);
        waitStart(10, got);
        pulseDone();
        rxPkt(mk(1, 0, (sid + d) % 8));
        waitStart(25, got);
        chk("R6 no resend after reply", got, 0);
        readAlerts(a);
        if (d == 0) chk("R3 matching id success", a, 5'b00100);
        else        chk("R6 wrong id discard", a, 5'b10001);
        repeat (BL + 2) @(negedge clk);
      end
    end

    // R6: GoodCRC with objects is not an ack, and it is answered
    request(mk(4, 1, 2), 1'b0);
    waitStart(10, got);
    pulseDone();
    rxPkt(mk(1, 1, 2));
    waitStart(10, got);
    chk("R9 answer to counted goodcrc", got, 1);
    chk("R9 answer header", sendHeader, replyOf(2, 0, 0));
    pulseDone();
    waitStart(25, got);
    chk("R6 no resend after counted goodcrc", got, 0);
    readAlerts(a);
    chk("R6 counted goodcrc discard", a, 5'b10001);

    // R6: hard reset received during the wait
    request(mk(4, 0, 1), 1'b0);
    waitStart(10, got);
    pulseDone();
    rxHardReset = 1'b1; @(negedge clk); rxHardReset = 1'b0;
    waitStart(25, got);
    chk("R6 no resend after rx hard reset", got, 0);
    readAlerts(a);
    chk("R6 rx hard reset in wait", a, 5'b10010);

    // R7: collisions
    for (int h = 0; h < 2; h++) begin
      request(mk(6, 0, 4), 1'(h));
      waitStart(10, got);
      pulseCollide();
      waitStart(25, got);
      chk("R7 no resend after collision", got, 0);
      readAlerts(a);
      chk("R7 collision discard", a, 5'b10000);
    end

    // R8: hard reset send
    request(mk(0, 0, 0), 1'b1);
    waitStart(10, got);
    chk("R8 hard start", got, 1);
    chk("R8 hard flag", sendHardReset, 1);
    pulseDone();
    chk("R8 success at once", alerts, 5'b00100);
    waitStart(10, got);
    chk("R8 no resend", got, 0);
    readAlerts(a);

    // R9: answers for every ID and role combination
    for (int r = 0; r < 4; r++) begin
      for (int id = 0; id < 8; id++) begin
        powerRole = r[1]; dataRole = r[0];
        rxPkt(mk(3, 2, id));
        waitStart(10, got);
        chk("R9 answer sent", got, 1);
        chk("R9 answer header", sendHeader, replyOf(id, r[1], r[0]));
        chk("R9 answer not hard", sendHardReset, 0);
        pulseDone();
        readAlerts(a);
        chk("R10 rx message alert", a, 5'b00001);
      end
    end
    powerRole = 0; dataRole = 0;

    // R9: bare GoodCRC is not answered
    rxPkt(mk(1, 0, 5));
    waitStart(10, got);
    chk("R9 bare goodcrc unanswered", got, 0);
    readAlerts(a);
    chk("R10 bare goodcrc alert", a, 5'b00001);

    // R9: answer goes ahead of a waiting request
    txHeader = mk(7, 0, 3); txHardReset = 0; txReq = 1;
    rxHeader = mk(3, 0, 6); rxValid = 1;
    @(negedge clk);
    txReq = 0; rxValid = 0;
    waitStart(10, got);
    chk("R9 answer first", sendHeader, replyOf(6, 0, 0));
    pulseDone();
    waitStart(10, got);
    chk("R9 request second", sendHeader, mk(7, 0, 3));
    pulseDone();
    rxPkt(mk(1, 0, 3));
    readAlerts(a);
    chk("R9 priority result", a, 5'b00101);
    repeat (BL + 2) @(negedge clk);

    // R2: request while pending is dropped
    request(mk(2, 0, 2), 1'b0);
    request(mk(2, 0, 5), 1'b0);
    waitStart(10, got);
    chk("R2 first header kept", sendHeader, mk(2, 0, 2));
    pulseDone();
    rxPkt(mk(1, 0, 2));
    waitStart(30, got);
    chk("R2 second request ignored", got, 0);
    readAlerts(a);
    chk("R2 single success", a, 5'b00100);
    repeat (BL + 2) @(negedge clk);

    // R12: probe swept across the blanking window
    for (int j = 1; j <= BL + 2; j++) begin
      request(mk(2, 0, 1), 1'b0);
      waitStart(10, got);
      pulseDone();
      rxHeader = mk(1, 0, 1); rxValid = 1;
      @(negedge clk);
      rxValid = 0;
      repeat (j - 1) @(negedge clk);
      rxPkt(mk(3, 0, 7));
      waitStart(10, got);
      if (j <= BL) begin
        chk("R12 blanked no answer", got, 0);
        readAlerts(a);
        chk("R12 blanked no alert", a, 5'b00100);
      end else begin
        chk("R12 live answer", got, 1);
        pulseDone();
        readAlerts(a);
        chk("R12 live alert", a, 5'b00101);
      end
      repeat (BL + 2) @(negedge clk);
    end

    // R12: hard reset inside the window is ignored
    request(mk(2, 0, 1), 1'b0);
    waitStart(10, got);
    pulseDone();
    rxPkt(mk(1, 0, 1));
    rxHardReset = 1; @(negedge clk); rxHardReset = 0;
    repeat (BL + 2) @(negedge clk);
    readAlerts(a);
    chk("R12 blanked hard reset", a, 5'b00100);

    // R10 and R11: accumulation, set-wins, clear
    rxHardReset = 1; @(negedge clk); rxHardReset = 0;
    rxPkt(mk(1, 0, 0));
    readAlerts(a);
    chk("R11 accumulate", a, 5'b00011);
    chk("R11 cleared", alerts, 0);
    rxHardReset = 1; alertRead = 1;
    @(negedge clk);
    rxHardReset = 0; alertRead = 0;
    chk("R11 set wins over read", alerts, 5'b00010);
    readAlerts(a);
    chk("R11 clear after read", alerts, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule